// File: doc/BRIEF.md
# Multi-slot retire queue controller

This block keeps the program order of in-flight instructions so that they leave the machine in order. The queue is a circular ring of slots. When the dispatcher sends an instruction, the instruction claims a run of consecutive slots, one for each of its micro-ops. The block returns a token, which is the ring index of the first slot of that run. Later, an execution-complete port names a token and marks that entry as finished.

Each cycle, the oldest entries leave the ring in order, beginning at the head. Retirement stops at the first entry that has not finished, or when the per-cycle lane count has been used up. A free-slot counter feeds a ready signal, which tells the dispatcher whether the next instruction fits in the ring.

The ring depth has two sources. One parameter gives the default buffer size. A second, optional parameter replaces it when it is nonzero. The number of retire lanes equals the configured maximum, and a maximum of zero gives one lane for every slot.

Top module: `retire_ring`

## Requirements
- R1: The ring depth is ROB_OVR when that parameter is nonzero, and UOP_BUF otherwise. After reset, disp_token is 0, free_slots equals the depth and ret_valid is all zero.
- R2: An instruction takes min(disp_uops, depth) slots, with a minimum of one slot. A zero micro-op instruction therefore takes exactly one slot.
- R3: disp_ready is high exactly when free_slots is at least the slot count of the presented request. A disp_valid given while disp_ready is low changes neither disp_token nor free_slots.
- R4: disp_token always shows the current tail index. An accepted dispatch moves the tail forward by the slot count, modulo the depth, and lowers free_slots by the same count.
- R5: A legal done_valid on a token sets that entry's executed flag. The entry can retire no earlier than the cycle after the done cycle.
- R6: done_err is high in the same cycle whenever done_valid names a token that is not the first slot of a live entry, or names an entry that has already executed. Such a request has no other effect.
- R7: Retirement starts at the head and moves forward in ring order. It stops at the first entry that has not executed. ret_valid lanes are filled from lane 0 with no gaps. Lane k of ret_tag (bits k*TAG_W and up) carries the tag of the k-th entry retired in that cycle.
- R8: At most MAX_RET entries retire in one cycle, and the remaining entries retire in later cycles. With MAX_RET = 0, every entry in the ring can retire in a single cycle.
- R9: A retiring entry returns its slot count to free_slots and moves the head past its slots. An entry that fills the whole ring retires exactly once.
- R10: When a dispatch and a retirement happen in the same cycle, free_slots becomes the old value minus the slots taken plus the slots returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_uops | input | UOP_W | Micro-op count of the request |
| disp_tag | input | TAG_W | Instruction tag stored with the entry |
| disp_ready | output | 1 | The request fits in the free slots |
| disp_token | output | IDX_W | Token granted to the request (tail index) |
| done_valid | input | 1 | Execution-complete event |
| done_token | input | IDX_W | Token of the finished entry |
| done_err | output | 1 | Illegal execution-complete event |
| ret_valid | output | LANES | Retire pulse for each lane |
| ret_tag | output | LANES*TAG_W | Tags of the retired entries, lane 0 lowest |
| free_slots | output | CNT_W | Number of unclaimed slots |

## Verification
The first build sets UOP_BUF = 16 with an override of 8 and MAX_RET = 2. This makes the override path visible at reset. It also exercises a capped retire of three ready entries over two cycles, a two-slot claim that wraps the tail from 7 to 1, and a twelve micro-op claim that is clamped to fill all eight slots, so one entry covers the whole ring. The second build keeps the default depth of 4 with MAX_RET = 0. It fills the ring with four entries that finish in reverse order, so all four must retire together in one cycle, with their tags in order.

// File: rtl/retire_ring_pkg.sv
package retire_ring_pkg;

  // Ring size: an explicit override wins over the buffer default.
  function automatic int unsigned pick_depth(input int unsigned uop_buf,
                                             input int unsigned rob_ovr);
    return (rob_ovr != 0) ? rob_ovr : uop_buf;
  endfunction

  // Retire lane count: zero means one lane per ring slot.
  function automatic int unsigned lane_count(input int unsigned max_ret,
                                             input int unsigned depth);
    return (max_ret == 0 || max_ret > depth) ? depth : max_ret;
  endfunction

  // Slots claimed by a request: clamp to the ring, never below one.
  function automatic int unsigned slot_norm(input int unsigned uops,
                                            input int unsigned depth);
    int unsigned n;
    n = (uops > depth) ? depth : uops;
    if (n == 0) n = 1;
    return n;
  endfunction

  // Modular advance; base < depth and step <= depth, so one subtract suffices.
  function automatic int unsigned ring_step(input int unsigned base,
                                            input int unsigned step,
                                            input int unsigned depth);
    int unsigned s;
    s = base + step;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

endpackage

// File: rtl/rr_entry_file.sv
module rr_entry_file #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4,
  parameter int TAG_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [CNT_W-1:0]       wr_cnt,
  input  logic [TAG_W-1:0]       wr_tag,
  input  logic                   mark_en,
  input  logic [IDX_W-1:0]       mark_idx,
  input  logic [DEPTH-1:0]       clr_mask,
  output logic [DEPTH-1:0]       live_o,
  output logic [DEPTH-1:0]       exec_o,
  output logic [DEPTH*CNT_W-1:0] cnt_o,
  output logic [DEPTH*TAG_W-1:0] tag_o
);

  logic [DEPTH-1:0] live_q, live_n;
  logic [DEPTH-1:0] exec_q, exec_n;
  logic [CNT_W-1:0] cnt_q [DEPTH];
  logic [TAG_W-1:0] tag_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic wr_hit, mk_hit;
    assign wr_hit    = wr_en && (wr_idx == IDX_W'(i));
    assign mk_hit    = mark_en && (mark_idx == IDX_W'(i));
    // retire clears first, a new claim sets the live bit, marking sets executed
    assign live_n[i] = (live_q[i] & ~clr_mask[i]) | wr_hit;
    assign exec_n[i] = (exec_q[i] & ~clr_mask[i] & ~wr_hit) | mk_hit;
    assign cnt_o[i*CNT_W +: CNT_W] = cnt_q[i];
    assign tag_o[i*TAG_W +: TAG_W] = tag_q[i];

    // R5: only an executed live entry may be cleared by retirement
    p_clr_needs_exec_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_mask[i] |-> (live_q[i] && exec_q[i]));
    // R4: the tail never lands on a live entry
    p_claim_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |-> !live_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      exec_q <= '0;
    end else begin
      live_q <= live_n;
      exec_q <= exec_n;
    end
  end

  // payload storage: no reset, written under the claim enable
  always_ff @(posedge clk) begin
    if (wr_en) begin
      cnt_q[wr_idx] <= wr_cnt;
      tag_q[wr_idx] <= wr_tag;
    end
  end

  assign live_o = live_q;
  assign exec_o = exec_q;

endmodule

// File: rtl/rr_retire_scan.sv
module rr_retire_scan
  import retire_ring_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4,
  parameter int TAG_W = 8,
  parameter int LANES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IDX_W-1:0]       head,
  input  logic [CNT_W-1:0]       used,
  input  logic [DEPTH-1:0]       live,
  input  logic [DEPTH-1:0]       exec,
  input  logic [DEPTH*CNT_W-1:0] cnt_flat,
  input  logic [DEPTH*TAG_W-1:0] tag_flat,
  output logic [LANES-1:0]       fire,
  output logic [LANES*TAG_W-1:0] fire_tag,
  output logic [DEPTH-1:0]       clr_mask,
  output logic [CNT_W-1:0]       slots_back,
  output logic [IDX_W-1:0]       head_next
);

  always_comb begin
    int unsigned p;
    int unsigned taken;
    int unsigned c;
    logic        go;
    p        = 32'(head);
    taken    = 0;
    go       = 1'b1;
    fire     = '0;
    fire_tag = '0;
    clr_mask = '0;
    for (int k = 0; k < LANES; k++) begin
      c = 32'(cnt_flat[p*CNT_W +: CNT_W]);
      // the slot budget stops a ring-filling entry from being seen twice
      if (go && (taken < 32'(used)) && live[p] && exec[p]) begin
        fire[k]                      = 1'b1;
        fire_tag[k*TAG_W +: TAG_W]   = tag_flat[p*TAG_W +: TAG_W];
        clr_mask[p]                  = 1'b1;
        taken                        = taken + c;
        p                            = ring_step(p, c, DEPTH);
      end else begin
        go = 1'b0;
      end
    end
    slots_back = CNT_W'(taken);
    head_next  = IDX_W'(p);
  end

  // R7: lanes fill from lane 0 without gaps
  p_lanes_packed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire & (fire + 1'b1)) == '0);
  // R9: never returns more slots than are occupied
  p_return_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slots_back <= used);

endmodule

// File: rtl/retire_ring.sv
module retire_ring
  import retire_ring_pkg::*;
#(
  parameter int UOP_BUF = 8,
  parameter int ROB_OVR = 0,
  parameter int UOP_W   = 4,
  parameter int TAG_W   = 8,
  parameter int MAX_RET = 2,
  localparam int DEPTH  = int'(pick_depth(UOP_BUF, ROB_OVR)),
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int LANES  = int'(lane_count(MAX_RET, DEPTH))
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   disp_valid,
  input  logic [UOP_W-1:0]       disp_uops,
  input  logic [TAG_W-1:0]       disp_tag,
  output logic                   disp_ready,
  output logic [IDX_W-1:0]       disp_token,
  input  logic                   done_valid,
  input  logic [IDX_W-1:0]       done_token,
  output logic                   done_err,
  output logic [LANES-1:0]       ret_valid,
  output logic [LANES*TAG_W-1:0] ret_tag,
  output logic [CNT_W-1:0]       free_slots
);

  logic [IDX_W-1:0]       head_q, head_n, tail_q, tail_n;
  logic [CNT_W-1:0]       free_q, free_n;
  logic [CNT_W-1:0]       need_slots, used_slots, back_slots;
  logic [DEPTH-1:0]       live_v, exec_v, clr_mask;
  logic [DEPTH*CNT_W-1:0] cnt_flat;
  logic [DEPTH*TAG_W-1:0] tag_flat;
  logic                   accept, tok_ok, mark_en;

  // dispatch side
  assign need_slots = CNT_W'(slot_norm(32'(disp_uops), DEPTH));
  assign disp_ready = (free_q >= need_slots);
  assign accept     = disp_valid && disp_ready;
  assign disp_token = tail_q;
  assign used_slots = CNT_W'(DEPTH) - free_q;

  // completion side
  assign tok_ok   = (32'(done_token) < DEPTH);
  assign done_err = done_valid && (!tok_ok || !live_v[done_token] || exec_v[done_token]);
  assign mark_en  = done_valid && !done_err;

  // next state
  always_comb begin
    tail_n = tail_q;
    free_n = free_q + back_slots;
    if (accept) begin
      tail_n = IDX_W'(ring_step(32'(tail_q), 32'(need_slots), DEPTH));
      free_n = free_n - need_slots;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      free_q <= CNT_W'(DEPTH);
    end else begin
      head_q <= head_n;
      tail_q <= tail_n;
      free_q <= free_n;
    end
  end

  assign free_slots = free_q;

  rr_entry_file #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .TAG_W(TAG_W)
  ) u_entries (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (accept),
    .wr_idx   (tail_q),
    .wr_cnt   (need_slots),
    .wr_tag   (disp_tag),
    .mark_en  (mark_en),
    .mark_idx (done_token),
    .clr_mask (clr_mask),
    .live_o   (live_v),
    .exec_o   (exec_v),
    .cnt_o    (cnt_flat),
    .tag_o    (tag_flat)
  );

  rr_retire_scan #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .TAG_W(TAG_W), .LANES(LANES)
  ) u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .head       (head_q),
    .used       (used_slots),
    .live       (live_v),
    .exec       (exec_v),
    .cnt_flat   (cnt_flat),
    .tag_flat   (tag_flat),
    .fire       (ret_valid),
    .fire_tag   (ret_tag),
    .clr_mask   (clr_mask),
    .slots_back (back_slots),
    .head_next  (head_n)
  );

  // occupied slots as seen from the stored entries
  int unsigned live_sum;
  always_comb begin
    live_sum = 0;
    for (int i = 0; i < DEPTH; i++)
      if (live_v[i]) live_sum = live_sum + 32'(cnt_flat[i*CNT_W +: CNT_W]);
  end

  // R3: a refused request leaves the tail where it was
  p_hold_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> $stable(tail_q));
  // R4: the free count never exceeds the ring
  p_free_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(free_q) <= DEPTH);
  // R9: free slots plus slots held by live entries always cover the ring
  p_slot_conserve_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(free_q) + live_sum) == DEPTH);

endmodule

// File: tb/retire_ring_test.sv
module retire_ring_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit reported = 1'b0;

  // build A: depth 8 by override, two lanes
  logic        dv = 0, cv = 0;
  logic [3:0]  du = 0;
  logic [7:0]  dt = 0;
  logic [2:0]  ct = 0;
  logic        rdy, err;
  logic [2:0]  tok;
  logic [1:0]  rv;
  logic [15:0] rt;
  logic [3:0]  fs;

  retire_ring #(.UOP_BUF(16), .ROB_OVR(8), .UOP_W(4), .TAG_W(8), .MAX_RET(2)) uut (
    .clk(clk), .rst_n(rst_n), .disp_valid(dv), .disp_uops(du), .disp_tag(dt),
    .disp_ready(rdy), .disp_token(tok), .done_valid(cv), .done_token(ct),
    .done_err(err), .ret_valid(rv), .ret_tag(rt), .free_slots(fs));

  // build B: default depth 4, unlimited lanes
  logic        nv = 0, ncv = 0;
  logic [3:0]  nu = 0;
  logic [7:0]  nt = 0;
  logic [1:0]  nct = 0;
  logic        nrdy, nerr;
  logic [1:0]  ntok;
  logic [3:0]  nrv;
  logic [31:0] nrt;
  logic [2:0]  nfs;

  retire_ring #(.UOP_BUF(4), .ROB_OVR(0), .UOP_W(4), .TAG_W(8), .MAX_RET(0)) uut_b (
    .clk(clk), .rst_n(rst_n), .disp_valid(nv), .disp_uops(nu), .disp_tag(nt),
    .disp_ready(nrdy), .disp_token(ntok), .done_valid(ncv), .done_token(nct),
    .done_err(nerr), .ret_valid(nrv), .ret_tag(nrt), .free_slots(nfs));

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // inputs change at the falling edge; state is read one falling edge later
  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    du = 4'd1; #1;
    chk("R1", "free after reset (override 8)", 32'(fs), 8);
    chk("R1", "token after reset", 32'(tok), 0);
    chk("R1", "no retire after reset", 32'(rv), 0);
    chk("R1", "build B free (default 4)", 32'(nfs), 4);
    chk("R1", "build B token", 32'(ntok), 0);
    chk("R3", "ready on empty ring", 32'(rdy), 1);
  endtask

  task automatic t_claim;
    dv = 1; du = 4'd0; dt = 8'hA0; #1;
    chk("R4", "first token", 32'(tok), 0);
    tick;
    du = 4'd3; dt = 8'hA1; #1;
    chk("R2", "zero uops took one slot", 32'(tok), 1);
    chk("R4", "free after one slot", 32'(fs), 7);
    tick;
    dv = 0; du = 4'd5; #1;
    chk("R4", "token after three slots", 32'(tok), 4);
    chk("R4", "free after three slots", 32'(fs), 4);
    chk("R3", "ready low for 5 > 4", 32'(rdy), 0);
    du = 4'd15; #1;
    chk("R3", "ready low for clamped 8 > 4", 32'(rdy), 0);
    du = 4'd4; #1;
    chk("R3", "ready high for 4 == 4", 32'(rdy), 1);
    dv = 1; du = 4'd6; dt = 8'hEE;
    tick;
    dv = 0; #1;
    chk("R3", "refused request kept token", 32'(tok), 4);
    chk("R3", "refused request kept free", 32'(fs), 4);
  endtask

  task automatic t_order;
    cv = 1; ct = 3'd1; #1;
    chk("R7", "no retire while head not done", 32'(rv), 0);
    chk("R6", "legal done no error", 32'(err), 0);
    tick;
    ct = 3'd0; #1;
    chk("R7", "younger done alone retires nothing", 32'(rv), 0);
    chk("R5", "no retire in the done cycle", 32'(rv), 0);
    tick;
    cv = 0; #1;
    chk("R7", "two lanes fire", 32'(rv), 3);
    chk("R7", "lane 0 tag", 32'(rt[7:0]), 32'h A0);
    chk("R7", "lane 1 tag", 32'(rt[15:8]), 32'h A1);
    tick;
    chk("R9", "slots returned", 32'(fs), 8);
    chk("R9", "no further retire", 32'(rv), 0);
  endtask

  task automatic t_bad_done;
    cv = 1; ct = 3'd4; #1;
    chk("R6", "done on empty slot", 32'(err), 1);
    ct = 3'd0; #1;
    chk("R6", "done on retired entry", 32'(err), 1);
    ct = 3'd2; #1;
    chk("R6", "done inside a former span", 32'(err), 1);
    tick;
    cv = 0; #1;
    chk("R6", "bad done caused no retire", 32'(rv), 0);
    chk("R6", "bad done left free", 32'(fs), 8);
  endtask

  task automatic t_cap_wrap;
    dv = 1; du = 4'd1; dt = 8'h10; #1;
    chk("R4", "token B0", 32'(tok), 4);
    tick; dt = 8'h11; tick; dt = 8'h12; tick;
    dv = 0; cv = 1; ct = 3'd6; #1;
    chk("R7", "tail entry done, head not", 32'(rv), 0);
    tick; ct = 3'd5; tick; ct = 3'd4; #1;
    chk("R5", "head marked this cycle, no retire yet", 32'(rv), 0);
    tick;
    cv = 0; dv = 1; du = 4'd2; dt = 8'h13; #1;
    chk("R4", "token B3", 32'(tok), 7);
    chk("R8", "capped at two lanes", 32'(rv), 3);
    chk("R8", "lane 0 B0", 32'(rt[7:0]), 32'h10);
    chk("R8", "lane 1 B1", 32'(rt[15:8]), 32'h11);
    tick;
    dv = 0; #1;
    chk("R8", "remaining entry next cycle", 32'(rv), 1);
    chk("R8", "lane 0 B2", 32'(rt[7:0]), 32'h12);
    chk("R10", "free after claim plus return", 32'(fs), 5);
    chk("R4", "tail wrapped 7+2 -> 1", 32'(tok), 1);
    tick;
    chk("R9", "free after B2", 32'(fs), 6);
    chk("R7", "B3 not done, no retire", 32'(rv), 0);
    cv = 1; ct = 3'd7; #1;
    chk("R6", "first done on B3 legal", 32'(err), 0);
    tick;
    #1;
    chk("R6", "second done on B3 flagged", 32'(err), 1);
    chk("R5", "B3 retires next cycle", 32'(rv), 1);
    chk("R7", "B3 tag", 32'(rt[7:0]), 32'h13);
    tick;
    cv = 0; #1;
    chk("R9", "ring empty again", 32'(fs), 8);
    chk("R4", "token kept", 32'(tok), 1);
  endtask

  task automatic t_full_ring;
    dv = 1; du = 4'd12; dt = 8'h20; #1;
    chk("R3", "ring-sized claim ready", 32'(rdy), 1);
    tick;
    dv = 0; du = 4'd0; #1;
    chk("R2", "12 uops clamped to 8", 32'(fs), 0);
    chk("R4", "tail back at 1", 32'(tok), 1);
    chk("R3", "full ring refuses one slot", 32'(rdy), 0);
    cv = 1; ct = 3'd1;
    tick;
    cv = 0; #1;
    chk("R9", "whole-ring entry retires once", 32'(rv), 1);
    chk("R9", "whole-ring tag", 32'(rt[7:0]), 32'h20);
    tick;
    chk("R9", "all slots back", 32'(fs), 8);
    chk("R9", "no repeat retire", 32'(rv), 0);
  endtask

  task automatic t_unlimited;
    nv = 1; nu = 4'd1;
    for (int i = 0; i < 4; i++) begin
      nt = 8'(8'h30 + i); #1;
      chk("R4", "build B token", 32'(ntok), 32'(i));
      tick;
    end
    nv = 0; #1;
    chk("R3", "build B full", 32'(nrdy), 0);
    chk("R4", "build B free zero", 32'(nfs), 0);
    ncv = 1;
    for (int i = 3; i >= 0; i--) begin
      nct = 2'(i); #1;
      chk("R7", "build B waits for head", 32'(nrv), 0);
      tick;
    end
    ncv = 0; #1;
    chk("R8", "unlimited: all four retire", 32'(nrv), 15);
    chk("R8", "tags in order", nrt, 32'h33323130);
    tick;
    chk("R9", "build B empty", 32'(nfs), 4);
  endtask

  task automatic summary;
    if (!reported) begin
      reported = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_claim();
    t_order();
    t_bad_done();
    t_cap_wrap();
    t_full_ring();
    t_unlimited();
    summary();
    $finish;
  end

endmodule